// File: doc/BRIEF.md
# Buffer-Full Flow Control Responder

This block sits beside one port of a switch and decides how that port pushes back on its link partner when the packet memory runs short. The packet memory hands out storage in 256-byte blocks. A maximum-size frame of 1522 bytes spans six blocks, so a frame that begins while fewer than six blocks are free counts as the start of congestion. The congestion lasts until the free count climbs back to six or more.

On a half-duplex port the block asks the transmit path to jam the receiving port for as long as congestion lasts and the port is receiving. On a full-duplex port it asks the pause-frame generator, through a request/acknowledge handshake, for a pause frame with a nonzero quanta when congestion begins. It asks for a zero-quanta pause frame once congestion clears. Each reaction has its own enable, taken from a strap pin while reset is held. When an enable is off, the block stays silent and the buffer manager drops the frame. Pause-on requests are rate limited to one per 1024 clock cycles.

Top module: `flow_ctl_responder`

## Requirements
- R1: The back-pressure and flow-control enables are taken from `strap_bp_en` and `strap_fc_en` while `rst_n` is low (1 = enabled). Strap changes after reset has been released have no effect.
- R2: Congestion starts only on a cycle where `frame_start` is 1 and `free_blocks` is below 6 (the 1522-byte maximum frame divided into 256-byte blocks, rounded up). A free count of 6 or more at frame start, or a low count with no frame start, starts nothing.
- R3: On a half-duplex port (`full_duplex` = 0) with back pressure enabled, `jam_req` is 1 from the cycle after congestion starts, for as long as congestion lasts and `rx_active` is 1.
- R4: Congestion ends on the first rising edge at which `free_blocks` is 6 or more, and `jam_req` is 0 from the following cycle.
- R5: With back pressure disabled, `jam_req` stays 0.
- R6: On a full-duplex port with flow control enabled, `pause_req` is 1 with `pause_quanta` = 16'hFFFF from the cycle after congestion starts (subject to R10). Both stay unchanged until the edge at which `pause_ack` is sampled 1, and `pause_req` is 0 from the next cycle.
- R7: When congestion ends after a pause-on request has been issued, `pause_req` is 1 with `pause_quanta` = 0 from the next cycle.
- R8: With flow control disabled, `pause_req` never rises.
- R9: Only one pause-on request is issued per congestion episode. Later frame starts during the same episode issue no further requests.
- R10: Two pause-on requests are issued at least 1024 cycles apart. A pause-on request for a new episode inside that window is deferred to exactly the 1024th cycle, unless the episode ends first.
- R11: `jam_req` is never 1 on a full-duplex port, and no pause-on request is issued for an episode that starts on a half-duplex port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps are sampled while it is low |
| strap_bp_en | input | 1 | Back-pressure enable strap |
| strap_fc_en | input | 1 | Full-duplex flow-control enable strap |
| full_duplex | input | 1 | 1 = port runs full duplex |
| rx_active | input | 1 | Port is currently receiving |
| frame_start | input | 1 | One-cycle pulse at the start of an incoming frame |
| free_blocks | input | FREE_W | Free 256-byte blocks reported by the buffer manager |
| pause_ack | input | 1 | Pause-frame generator accepts the current request |
| jam_req | output | 1 | Request a jam pattern on the receive port |
| pause_req | output | 1 | Pause-frame request, held until acknowledged |
| pause_quanta | output | 16 | Quanta for the requested pause frame |

## Verification
Every reaction registers once, so `jam_req` and `pause_req` both follow the edge that sampled the frame start or the recovered free count by exactly one cycle. `jam_req` also follows `rx_active` and `full_duplex` in the same cycle. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each check lands on the first cycle where the result is due. The rate-limit check counts rising edges between the two observed pause-on launches and expects exactly 1024.

// File: rtl/flow_ctl_responder.sv
module flow_ctl_responder #(
  parameter int          BLOCK_BYTES     = 256,
  parameter int          MAX_FRAME_BYTES = 1522,
  parameter int          FREE_W          = 11,
  parameter int          RATE_GAP        = 1024,
  parameter logic [15:0] PAUSE_ON_QUANTA = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_bp_en,
  input  logic              strap_fc_en,
  input  logic              full_duplex,
  input  logic              rx_active,
  input  logic              frame_start,
  input  logic [FREE_W-1:0] free_blocks,
  input  logic              pause_ack,
  output logic              jam_req,
  output logic              pause_req,
  output logic [15:0]       pause_quanta
);

  localparam int NEED_BLOCKS = (MAX_FRAME_BYTES + BLOCK_BYTES - 1) / BLOCK_BYTES;
  localparam int GAP_W       = $clog2(RATE_GAP);
  localparam int MON_W       = GAP_W + 1;

  logic             bp_en_q, fc_en_q;
  logic             cong_q;
  logic             on_pending_q, off_pending_q, on_sent_q;
  logic             req_q;
  logic [15:0]      quanta_q;
  logic [GAP_W-1:0] gap_q;

  // enables latched from straps while reset is held (R1)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp_en_q <= strap_bp_en;
      fc_en_q <= strap_fc_en;
    end
  end

  wire short_buf = free_blocks < FREE_W'(NEED_BLOCKS);
  wire cong_set  = !cong_q && frame_start && short_buf;
  wire cong_clr  = cong_q && !short_buf;
  wire ep_start  = cong_set && full_duplex && fc_en_q;

  wire on_want   = (on_pending_q || ep_start) && !cong_clr;
  wire off_want  = (off_pending_q && !ep_start) || (cong_clr && on_sent_q);
  wire go_off    = !req_q && off_want;
  wire go_on     = !req_q && !off_want && on_want && (gap_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cong_q        <= 1'b0;
      on_pending_q  <= 1'b0;
      off_pending_q <= 1'b0;
      on_sent_q     <= 1'b0;
      req_q         <= 1'b0;
      quanta_q      <= '0;
      gap_q         <= '0;
    end else begin
      if (cong_set)      cong_q <= 1'b1;
      else if (cong_clr) cong_q <= 1'b0;

      on_pending_q  <= on_want && !go_on;
      off_pending_q <= off_want && !go_off;

      if (go_on)       on_sent_q <= 1'b1;
      else if (go_off) on_sent_q <= 1'b0;

      if (go_off) begin
        req_q    <= 1'b1;
        quanta_q <= '0;
      end else if (go_on) begin
        req_q    <= 1'b1;
        quanta_q <= PAUSE_ON_QUANTA;
      end else if (req_q && pause_ack) begin
        req_q <= 1'b0;
      end

      if (go_on)             gap_q <= GAP_W'(RATE_GAP - 1);
      else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
    end
  end

  assign jam_req      = cong_q && bp_en_q && !full_duplex && rx_active;
  assign pause_req    = req_q;
  assign pause_quanta = quanta_q;

  // checker state for pause-on spacing and per-episode count
  logic             prev_req_q;
  logic             seen_on_q;
  logic [MON_W-1:0] since_on_q;
  wire on_rise = pause_req && !prev_req_q && (pause_quanta != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_req_q <= 1'b0;
      seen_on_q  <= 1'b0;
      since_on_q <= MON_W'(RATE_GAP);
    end else begin
      prev_req_q <= pause_req;
      if (!cong_q)      seen_on_q <= 1'b0;
      else if (on_rise) seen_on_q <= 1'b1;
      if (on_rise)                          since_on_q <= MON_W'(1);
      else if (since_on_q < MON_W'(RATE_GAP)) since_on_q <= since_on_q + 1'b1;
    end
  end

  a_r3_jam_only_receiving: assert property (@(posedge clk) disable iff (!rst_n)
    jam_req |-> rx_active);
  a_r11_jam_half_only: assert property (@(posedge clk) disable iff (!rst_n)
    jam_req |-> !full_duplex);
  a_r5_bp_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !bp_en_q |-> !jam_req);
  a_r4_jam_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cong_q && !short_buf) |=> !jam_req);
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && !pause_ack) |=> (pause_req && $stable(pause_quanta)));
  a_r6_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && pause_ack) |=> !pause_req);
  a_r8_fc_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_req) |-> fc_en_q);
  a_r9_one_per_episode: assert property (@(posedge clk) disable iff (!rst_n)
    on_rise |-> !seen_on_q);
  a_r10_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    on_rise |-> (since_on_q >= MON_W'(RATE_GAP)));

endmodule

// File: tb/flow_ctl_responder_tb.sv
module flow_ctl_responder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_bp_en = 1'b1, strap_fc_en = 1'b1;
  logic        full_duplex = 1'b0, rx_active = 1'b0, frame_start = 1'b0;
  logic [10:0] free_blocks = 11'd100;
  logic        pause_ack = 1'b0;
  logic        jam_req, pause_req;
  logic [15:0] pause_quanta;

  int checks = 0, errors = 0, cyc = 0;

  flow_ctl_responder u_dut (
    .clk(clk), .rst_n(rst_n), .strap_bp_en(strap_bp_en), .strap_fc_en(strap_fc_en),
    .full_duplex(full_duplex), .rx_active(rx_active), .frame_start(frame_start),
    .free_blocks(free_blocks), .pause_ack(pause_ack),
    .jam_req(jam_req), .pause_req(pause_req), .pause_quanta(pause_quanta));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic bp, logic fc);
    rst_n = 1'b0; strap_bp_en = bp; strap_fc_en = fc;
    frame_start = 1'b0; pause_ack = 1'b0; free_blocks = 11'd100;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic pulse_frame(int fb);
    free_blocks = 11'(fb); frame_start = 1'b1;
    step(1);
    frame_start = 1'b0;
  endtask

  task automatic do_ack();
    pause_ack = 1'b1;
    step(1);
    pause_ack = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b1, 1'b1);
    check("R1 reset jam", jam_req, 0);
    check("R1 reset pause", pause_req, 0);
  endtask

  task automatic t_half_jam();
    do_reset(1'b1, 1'b1);
    strap_bp_en = 1'b0;
    full_duplex = 1'b0; rx_active = 1'b1;
    pulse_frame(5);
    check("R3 jam after start", jam_req, 1);
    check("R1 strap change ignored", jam_req, 1);
    check("R11 no pause in half duplex", pause_req, 0);
    step(3);
    check("R3 jam held", jam_req, 1);
    rx_active = 1'b0; step(1);
    check("R3 jam off when idle", jam_req, 0);
    rx_active = 1'b1; step(1);
    check("R3 jam back when receiving", jam_req, 1);
    free_blocks = 11'd6; step(1);
    check("R4 jam drops", jam_req, 0);
    pulse_frame(6);
    check("R2 six free no congestion", jam_req, 0);
    free_blocks = 11'd5; step(2);
    check("R2 low count without start", jam_req, 0);
    pulse_frame(0);
    check("R2 zero free congests", jam_req, 1);
    full_duplex = 1'b1; step(1);
    check("R11 no jam in full duplex", jam_req, 0);
    full_duplex = 1'b0; free_blocks = 11'd40; step(1);
    check("R4 jam drops again", jam_req, 0);
  endtask

  task automatic t_bp_off();
    do_reset(1'b0, 1'b1);
    full_duplex = 1'b0; rx_active = 1'b1;
    pulse_frame(2);
    step(4);
    check("R5 no jam when disabled", jam_req, 0);
    free_blocks = 11'd50; step(1);
  endtask

  task automatic t_full_pause();
    int t_first, t_second, waited;
    do_reset(1'b1, 1'b1);
    full_duplex = 1'b1; rx_active = 1'b1;
    pulse_frame(2);
    t_first = cyc;
    check("R6 pause on raised", pause_req, 1);
    check("R6 pause on quanta", pause_quanta, 16'hFFFF);
    check("R11 no jam full duplex", jam_req, 0);
    step(3);
    check("R6 held until ack", pause_req, 1);
    do_ack();
    check("R6 dropped after ack", pause_req, 0);
    pulse_frame(1);
    step(5);
    check("R9 single pause per episode", pause_req, 0);
    free_blocks = 11'd10; step(1);
    check("R7 pause off raised", pause_req, 1);
    check("R7 pause off quanta", pause_quanta, 0);
    do_ack();
    pulse_frame(3);
    check("R10 deferred inside window", pause_req, 0);
    waited = 0;
    while (!pause_req && waited < 1500) begin
      step(1); waited++;
    end
    t_second = cyc;
    check("R10 spacing", t_second - t_first, 1024);
    check("R10 deferred quanta", pause_quanta, 16'hFFFF);
    do_ack();
    free_blocks = 11'd30; step(1);
    check("R7 second pause off", pause_req, 1);
    do_ack();
  endtask

  task automatic t_fc_off();
    do_reset(1'b1, 1'b0);
    full_duplex = 1'b1; rx_active = 1'b1;
    pulse_frame(1);
    step(10);
    check("R8 no pause when disabled", pause_req, 0);
    free_blocks = 11'd20; step(2);
    check("R8 no pause off either", pause_req, 0);
  endtask

  task automatic t_half_no_pause();
    do_reset(1'b1, 1'b1);
    full_duplex = 1'b0; rx_active = 1'b1;
    pulse_frame(4);
    full_duplex = 1'b1; step(3);
    check("R11 half start gives no pause", pause_req, 0);
    free_blocks = 11'd20; step(1);
  endtask

  initial begin
    t_reset_state();
    t_half_jam();
    t_bp_off();
    t_full_pause();
    t_fc_off();
    t_half_no_pause();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule